// File: doc/BRIEF.md
# Converter Host Register Interface

This block is the register window through which a host processor drives the converter section of a data-acquisition board. A control register selects one of sixteen interrupt-line codes and holds an interrupt-enable bit and two general-purpose output bits. A read-only status word reports whether the converter is busy, whether a completion is waiting to be acknowledged, the two sampled digital input pins, and the current line code.

The block watches start and done pulses from the converter. It keeps a busy flag, and it latches a request flag on every completion, whether or not interrupts are enabled. When the request flag and the enable bit are both set, it drives exactly one line of a 16-wide host interrupt vector, chosen by the line code. Only ten of the sixteen codes map to a line. A write of any data to the status offset acknowledges the request.

Top module: `acq_host_regs`

## Requirements
- R1: After reset, the request flag, enable bit, both output bits and the line code are 0, and `irq_lines` and `gp_out` are all zero.
- R2: When `rd_en` is high and `addr` is 3, `rdata` returns, from bit 7 down to bit 0: busy, request, pin 1, pin 0, code[3:0]. `rdata` is 0 when `rd_en` is low or `addr` is any other value.
- R3: A write at `addr` 2 loads code = `wdata[3:0]`, enable = `wdata[4]`, out0 = `wdata[5]` and out1 = `wdata[6]`. `gp_out[0]` shows out0 and `gp_out[1]` shows out1. The enable and output bits never appear in `rdata`.
- R4: `conv_start` sets busy and `conv_done` clears it on the next edge. If both arrive in the same cycle, busy ends set.
- R5: `conv_done` sets the request flag on the next edge, whether the enable bit is 0 or 1.
- R6: A write of any data at `addr` 3 clears the request flag on the next edge.
- R7: If `conv_done` and a write at `addr` 3 fall in the same cycle, the request flag ends the cycle set.
- R8: With the request flag and the enable bit both 1, codes 2, 3, 4, 5, 7, 9, 10, 11, 12 and 15 drive only `irq_lines[code]` high.
- R9: Codes 0, 1, 6, 8, 13 and 14 drive no interrupt line.
- R10: All interrupt lines stay low when the request flag or the enable bit is 0. At most one line is high at any time.
- R11: `din` is registered on each clock edge and appears in status bits 5:4 one cycle after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register offset |
| wr_en | input | 1 | Write strobe for this cycle |
| rd_en | input | 1 | Read strobe for this cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| conv_start | input | 1 | Conversion start pulse |
| conv_done | input | 1 | Conversion complete pulse |
| din | input | 2 | Digital input pins |
| gp_out | output | 2 | General-purpose output bits |
| irq_lines | output | 16 | Host interrupt lines, at most one high |

## Verification
Two events can land in the same clock: a completion pulse that sets the request flag, and an acknowledge write that clears it. Start and done pulses can also coincide on the busy flag. The bench drives each pair in one cycle, both from a cleared flag and from a set flag. It then judges the outcome only through the status read and the interrupt vector on the following cycle: the request must survive and busy must stay set.

// File: rtl/acq_regs_pkg.sv
package acq_regs_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned LVL_W    = 4;
  localparam int unsigned N_LINES  = 1 << LVL_W;
  localparam int unsigned PIN_W    = 2;
  localparam int unsigned CTRL_OFS = 2;
  localparam int unsigned STAT_OFS = 3;

  typedef struct packed {
    logic             out1;
    logic             out0;
    logic             en;
    logic [LVL_W-1:0] lvl;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  // Codes that reach a host line; the line number equals the code.
  function automatic logic code_routable(input logic [LVL_W-1:0] code);
    case (code)
      4'd2, 4'd3, 4'd4, 4'd5, 4'd7,
      4'd9, 4'd10, 4'd11, 4'd12, 4'd15: return 1'b1;
      default:                          return 1'b0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] status_word(
    input logic busy, input logic req,
    input logic [PIN_W-1:0] pins, input logic [LVL_W-1:0] lvl);
    return {busy, req, pins[1], pins[0], lvl};
  endfunction
endpackage

// File: rtl/acq_ctrl_reg.sv
module acq_ctrl_reg
  import acq_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CTRL_W-1:0] din,
  output ctrl_t             q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (load) q <= ctrl_t'(din);
  end

  // R3
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == ctrl_t'($past(din))));
  // R3
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/acq_conv_flags.sv
module acq_conv_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_start,
  input  logic conv_done,
  input  logic ack,
  output logic busy,
  output logic req
);
  logic req_set_ev, req_clr_ev;
  assign req_set_ev = conv_done;
  assign req_clr_ev = ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      req  <= 1'b0;
    end else begin
      if (conv_start)     busy <= 1'b1;
      else if (conv_done) busy <= 1'b0;
      if (req_set_ev)      req <= 1'b1;
      else if (req_clr_ev) req <= 1'b0;
    end
  end

  // R4
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> busy);
  // R4
  busy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !conv_start) |=> !busy);
  // R5
  req_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_set_ev |=> req);
  // R6
  req_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_clr_ev && !req_set_ev) |=> !req);
  // R7
  req_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_clr_ev && req_set_ev) |=> req);
endmodule

// File: rtl/acq_irq_route.sv
module acq_irq_route
  import acq_regs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic               en,
  input  logic [LVL_W-1:0]   lvl,
  output logic [N_LINES-1:0] lines
);
  logic fire;
  assign fire = req && en;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    if (code_routable(LVL_W'(i))) begin : g_live
      assign lines[i] = fire && (lvl == LVL_W'(i));
    end else begin : g_dead
      assign lines[i] = 1'b0;
    end
  end

  // R10
  lines_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lines));
  // R10
  lines_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |-> (lines == '0));
  // R8
  lines_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lines != '0) |-> lines[lvl]);
endmodule

// File: rtl/acq_host_regs.sv
module acq_host_regs
  import acq_regs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic               conv_start,
  input  logic               conv_done,
  input  logic [PIN_W-1:0]   din,
  output logic [PIN_W-1:0]   gp_out,
  output logic [N_LINES-1:0] irq_lines
);
  logic wr_ctrl, wr_stat, rd_stat;
  assign wr_ctrl = wr_en && (addr == ADDR_W'(CTRL_OFS));
  assign wr_stat = wr_en && (addr == ADDR_W'(STAT_OFS));
  assign rd_stat = rd_en && (addr == ADDR_W'(STAT_OFS));

  logic unused_wbits;
  assign unused_wbits = ^wdata[DATA_W-1:CTRL_W];

  ctrl_t ctrl;
  logic  busy, req;
  logic [PIN_W-1:0] pins_q;

  acq_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .load(wr_ctrl),
    .din(wdata[CTRL_W-1:0]), .q(ctrl)
  );

  acq_conv_flags u_flags (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start),
    .conv_done(conv_done), .ack(wr_stat), .busy(busy), .req(req)
  );

  acq_irq_route u_route (
    .clk(clk), .rst_n(rst_n), .req(req), .en(ctrl.en),
    .lvl(ctrl.lvl), .lines(irq_lines)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins_q <= '0;
    else        pins_q <= din;
  end

  assign gp_out = {ctrl.out1, ctrl.out0};

  always_comb begin
    rdata = '0;
    if (rd_stat) rdata = status_word(busy, req, pins_q, ctrl.lvl);
  end

  // R2
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stat |-> (rdata == '0));
  // R11
  pins_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pins_q == $past(din)));
endmodule

// File: tb/acq_host_regs_test.sv
`timescale 1ns/1ps
module acq_host_regs_test;
  logic clk = 0, rst_n = 0;
  logic [1:0] addr = 0;
  logic wr_en = 0, rd_en = 0, conv_start = 0, conv_done = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic [1:0] din = 0, gp_out;
  logic [15:0] irq_lines;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  acq_host_regs uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .conv_start(conv_start),
    .conv_done(conv_done), .din(din), .gp_out(gp_out), .irq_lines(irq_lines)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] line_for(input int code);
    int live[10] = '{2, 3, 4, 5, 7, 9, 10, 11, 12, 15};
    foreach (live[k]) if (live[k] == code) return 16'(1) << code;
    return 16'h0;
  endfunction

  // Drive for one edge starting at a falling edge; returns at the next falling edge.
  task automatic cyc(input logic w, input logic [1:0] a, input logic [7:0] d,
                     input logic st, input logic dn);
    wr_en = w; addr = a; wdata = d; conv_start = st; conv_done = dn;
    @(posedge clk); @(negedge clk);
    wr_en = 0; conv_start = 0; conv_done = 0; wdata = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1; #1; d = rdata; rd_en = 0; #1;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(2'd3, d);
    check("R1 status", {8'h0, d}, 16'h0000);
    check("R1 lines", irq_lines, 16'h0);
    check("R1 gp_out", {14'h0, gp_out}, 16'h0);
  endtask

  task automatic t_readmap;
    logic [7:0] d;
    cyc(1, 2'd2, 8'h1B, 0, 0);          // code 11, enable 1
    for (int a = 0; a < 3; a++) begin
      rd(2'(a), d);
      check("R2 other offset", {8'h0, d}, 16'h0);
    end
    addr = 2'd3; rd_en = 0; #1;
    check("R2 rd_en low", {8'h0, rdata}, 16'h0);
    rd(2'd3, d);
    check("R2/R3 status echo", {8'h0, d}, 16'h000B);
  endtask

  task automatic t_ctrl;
    logic [7:0] d;
    cyc(1, 2'd2, 8'h75, 0, 0);          // out1=1 out0=1 en=1 code 5
    check("R3 gp_out both", {14'h0, gp_out}, 16'h3);
    rd(2'd3, d);
    check("R3 write-only hidden", {8'h0, d}, 16'h0005);
    cyc(1, 2'd2, 8'h23, 0, 0);          // out0 only
    check("R3 gp_out out0", {14'h0, gp_out}, 16'h1);
    cyc(1, 2'd2, 8'h40, 0, 0);          // out1 only
    check("R3 gp_out out1", {14'h0, gp_out}, 16'h2);
  endtask

  task automatic t_busy;
    logic [7:0] d;
    cyc(0, 2'd0, 0, 1, 0);
    rd(2'd3, d);
    check("R4 busy set", {15'h0, d[7]}, 16'h1);
    cyc(0, 2'd0, 0, 0, 1);
    rd(2'd3, d);
    check("R4 busy clear", {15'h0, d[7]}, 16'h0);
    cyc(0, 2'd0, 0, 1, 1);
    rd(2'd3, d);
    check("R4 start and done together", {15'h0, d[7]}, 16'h1);
    cyc(0, 2'd0, 0, 0, 1);
    cyc(1, 2'd3, 8'h00, 0, 0);
  endtask

  task automatic t_req_noen;
    logic [7:0] d;
    cyc(1, 2'd2, 8'h03, 0, 0);          // code 3, enable 0
    cyc(0, 2'd0, 0, 0, 1);
    rd(2'd3, d);
    check("R5 req without enable", {15'h0, d[6]}, 16'h1);
    check("R10 no line when disabled", irq_lines, 16'h0);
    cyc(1, 2'd2, 8'h13, 0, 0);          // enable 1
    check("R8 line 3 once enabled", irq_lines, 16'h0008);
  endtask

  task automatic t_ack;
    logic [7:0] d;
    cyc(1, 2'd3, 8'hA5, 0, 0);
    rd(2'd3, d);
    check("R6 ack clears req", {15'h0, d[6]}, 16'h0);
    check("R10 no line after ack", irq_lines, 16'h0);
  endtask

  task automatic t_collide;
    logic [7:0] d;
    cyc(1, 2'd3, 8'h00, 0, 1);          // from cleared
    rd(2'd3, d);
    check("R7 done+ack from clear", {15'h0, d[6]}, 16'h1);
    cyc(1, 2'd3, 8'hFF, 0, 1);          // from set
    rd(2'd3, d);
    check("R7 done+ack from set", {15'h0, d[6]}, 16'h1);
    check("R7 line stays up", irq_lines, 16'h0008);
  endtask

  task automatic t_route;
    for (int c = 0; c < 16; c++) begin
      cyc(1, 2'd2, 8'(8'h10 | c), 0, 0);
      check((line_for(c) != 0) ? $sformatf("R8 code %0d", c)
                               : $sformatf("R9 code %0d", c),
            irq_lines, line_for(c));
    end
  endtask

  task automatic t_pins;
    logic [7:0] d;
    din = 2'b10; @(posedge clk); @(negedge clk);
    rd(2'd3, d);
    check("R11 pins 10", {14'h0, d[5:4]}, 16'h2);
    din = 2'b01; #1;
    rd(2'd3, d);
    check("R11 not yet sampled", {14'h0, d[5:4]}, 16'h2);
    @(posedge clk); @(negedge clk);
    rd(2'd3, d);
    check("R11 pins 01", {14'h0, d[5:4]}, 16'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_readmap();
    t_ctrl();
    t_busy();
    t_req_noen();
    t_ack();
    t_collide();
    t_route();
    t_pins();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule